// File: doc/BRIEF.md
# Serial Five-Write Configuration Loader

This block is the control front end of a cartridge bank controller. The CPU cannot write a whole configuration word in one access. It sends one bit per bus write into the upper half of the address space, least significant bit first. The fifth accepted bit completes a 5-bit word. That word is stored into one of four configuration registers, and address bits 14 and 13 of the fifth write select which one. A write with data bit 7 set abandons any partial word. It also forces the control register into a known PRG arrangement.

A write that lands one or two CPU cycles after the previous write to the range is discarded. This covers the back-to-back writes that read-modify-write instructions produce. Each clock of the block is one CPU cycle. The four registers are brought out as they are. Next to them are the decoded nametable mirroring and the PRG and CHR mode bits. A downstream bank translator uses these outputs.

Top module: `shift_cfg_loader`

## Requirements
- R1: An in-range write with data bit 7 set clears the partial word and the bit count. It sets bits 3 and 2 of register 0 and leaves that register's other bits and registers 1 to 3 unchanged. This happens even while the filter is active.
- R2: An accepted write takes data bit 0 as the next bit of the word. Bits fill from position 0 upward in write order.
- R3: The fifth accepted write stores the 5-bit word into the register numbered by address bits [14:13]: 0 control, 1 CHR low, 2 CHR high, 3 PRG. It then clears the partial word and the count. The new value is visible one cycle after the write.
- R4: Every in-range write reloads a filter count to 2, whether it is accepted, filtered or a reset write. The count drops by one per cycle and saturates at 0. A bit write is accepted only while the count is 0, so a write 1 or 2 cycles after the previous in-range write is ignored and a write 3 cycles after it is accepted.
- R5: A write with address bit 15 low, or any cycle without the write strobe, changes no register, no partial word and no filter state.
- R6: After reset, register 0 holds 0x0C, registers 1 to 3 hold 0 and no bits are pending.
- R7: The mirroring output equals register 0 bits [1:0] XOR 3.
- R8: The 16 KiB PRG mode output is register 0 bit 3. The low-switch output is register 0 bit 2: 1 places the switchable bank at 0x8000 and 0 places it at 0xC000.
- R9: The 4 KiB CHR mode output is register 0 bit 4. The 8 KiB CHR bank output is register 1 shifted right by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle pulse per CPU write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| ctrlReg | output | 5 | Register 0 (control) |
| chrLoReg | output | 5 | Register 1 (CHR low bank) |
| chrHiReg | output | 5 | Register 2 (CHR high bank) |
| prgReg | output | 5 | Register 3 (PRG bank) |
| mirror | output | 2 | Decoded mirroring code |
| prg16Mode | output | 1 | 16 KiB PRG switching selected |
| prgLowSwitch | output | 1 | Switchable 16 KiB bank at 0x8000 |
| chr4kMode | output | 1 | Two independent 4 KiB CHR banks |
| chr8kBank | output | 4 | 8 KiB CHR bank number |

## Verification
The assertions assume that the write strobe is low or high for a whole cycle and that address and data are steady while it is high. They also assume that reset is applied before the first write. The bench changes every input at the falling edge and never during the cycle's high phase. Random stimulus includes writes in consecutive cycles so that the filter path is exercised. It also includes writes below 0x8000 and occasional bit-7 writes, all within those assumptions.

// File: rtl/shift_cfg_pkg.sv
package shift_cfg_pkg;
  typedef struct packed {
    logic clearWord;
    logic loadBit;
    logic commit;
    logic forceCtl;
  } loadStrobes_t;
endpackage

// File: rtl/shift_cfg_ctrl.sv
module shift_cfg_ctrl
  import shift_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int VAL_W = 5,
  parameter int FILTER_LOAD = 2,
  localparam int CNT_W = $clog2(VAL_W + 1),
  localparam int FILT_W = $clog2(FILTER_LOAD + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output loadStrobes_t      strobes,
  output logic [CNT_W-1:0]  bitPos
);
  logic [CNT_W-1:0]  bitCnt;
  logic [FILT_W-1:0] filterCnt;
  logic inRange, isReset, accept, lastBit;

  assign inRange = wrStb && wrAddr[ADDR_W-1];
  assign isReset = inRange && wrData[DATA_W-1];
  assign accept  = inRange && !wrData[DATA_W-1] && (filterCnt == '0);
  assign lastBit = accept && (bitCnt == CNT_W'(VAL_W - 1));

  always_comb begin
    strobes.forceCtl  = isReset;
    strobes.loadBit   = accept && !lastBit;
    strobes.commit    = lastBit;
    strobes.clearWord = isReset || lastBit;
  end
  assign bitPos = bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      filterCnt <= '0;
    end else begin
      if (isReset || lastBit) bitCnt <= '0;
      else if (accept)        bitCnt <= bitCnt + 1'b1;
      if (inRange)                filterCnt <= FILT_W'(FILTER_LOAD);
      else if (filterCnt != '0)   filterCnt <= filterCnt - 1'b1;
    end
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(VAL_W));
  assert_filter_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    inRange |=> filterCnt == FILT_W'(FILTER_LOAD));
  assert_filter_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (filterCnt != '0) |-> !(strobes.loadBit || strobes.commit));
  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |=> $stable(bitCnt));
endmodule

// File: rtl/shift_cfg_datapath.sv
module shift_cfg_datapath
  import shift_cfg_pkg::*;
#(
  parameter int VAL_W = 5,
  parameter int NUM_REGS = 4,
  parameter logic [VAL_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [VAL_W-1:0] CTRL_FORCE = 5'h0C,
  localparam int CNT_W = $clog2(VAL_W + 1),
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  loadStrobes_t              strobes,
  input  logic [CNT_W-1:0]          bitPos,
  input  logic                      dataBit,
  input  logic [SEL_W-1:0]          selIdx,
  output logic [NUM_REGS*VAL_W-1:0] cfgFlat
);
  logic [VAL_W-1:0] shiftReg;
  logic [VAL_W-1:0] commitVal;

  assign commitVal = {dataBit, shiftReg[VAL_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.clearWord) shiftReg <= '0;
    else if (strobes.loadBit)   shiftReg[bitPos] <= dataBit;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cfg
    logic [VAL_W-1:0] regQ;
    logic hit;
    assign hit = strobes.commit && (selIdx == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)                         regQ <= (i == 0) ? CTRL_INIT : '0;
      else if (hit)                      regQ <= commitVal;
      else if (i == 0 && strobes.forceCtl) regQ <= regQ | CTRL_FORCE;
    end
    assign cfgFlat[i*VAL_W +: VAL_W] = regQ;
  end

  assert_force_ctl_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceCtl |=> (cfgFlat[VAL_W-1:0] & CTRL_FORCE) == CTRL_FORCE);
  assert_commit_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> shiftReg == '0);
  assert_hold_regs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit || strobes.forceCtl) |=> $stable(cfgFlat));
endmodule

// File: rtl/shift_cfg_loader.sv
module shift_cfg_loader
  import shift_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int VAL_W = 5,
  parameter int FILTER_LOAD = 2,
  localparam int NUM_REGS = 4,
  localparam int CNT_W = $clog2(VAL_W + 1),
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [VAL_W-1:0]  ctrlReg,
  output logic [VAL_W-1:0]  chrLoReg,
  output logic [VAL_W-1:0]  chrHiReg,
  output logic [VAL_W-1:0]  prgReg,
  output logic [1:0]        mirror,
  output logic              prg16Mode,
  output logic              prgLowSwitch,
  output logic              chr4kMode,
  output logic [VAL_W-2:0]  chr8kBank
);
  loadStrobes_t strobes;
  logic [CNT_W-1:0] bitPos;
  logic [NUM_REGS*VAL_W-1:0] cfgFlat;

  shift_cfg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W),
                   .FILTER_LOAD(FILTER_LOAD)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .bitPos(bitPos));

  shift_cfg_datapath #(.VAL_W(VAL_W), .NUM_REGS(NUM_REGS)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitPos(bitPos),
    .dataBit(wrData[0]), .selIdx(wrAddr[ADDR_W-2 -: SEL_W]), .cfgFlat(cfgFlat));

  assign ctrlReg  = cfgFlat[0*VAL_W +: VAL_W];
  assign chrLoReg = cfgFlat[1*VAL_W +: VAL_W];
  assign chrHiReg = cfgFlat[2*VAL_W +: VAL_W];
  assign prgReg   = cfgFlat[3*VAL_W +: VAL_W];

  assign mirror       = ctrlReg[1:0] ^ 2'b11;
  assign prg16Mode    = ctrlReg[3];
  assign prgLowSwitch = ctrlReg[2];
  assign chr4kMode    = ctrlReg[4];
  assign chr8kBank    = chrLoReg[VAL_W-1:1];
endmodule

// File: tb/test_shift_cfg_loader.sv
`timescale 1ns/1ps
module test_shift_cfg_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [4:0] ctrlReg, chrLoReg, chrHiReg, prgReg;
  logic [1:0] mirror;
  logic prg16Mode, prgLowSwitch, chr4kMode;
  logic [3:0] chr8kBank;

  int errors = 0;
  int checks = 0;

  logic [4:0] mRegs [4];
  logic [4:0] mShift;
  int mCnt, mFilt;

  always #2.5 clk = ~clk;

  shift_cfg_loader i_shift_cfg_loader (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlReg(ctrlReg), .chrLoReg(chrLoReg), .chrHiReg(chrHiReg), .prgReg(prgReg),
    .mirror(mirror), .prg16Mode(prg16Mode), .prgLowSwitch(prgLowSwitch),
    .chr4kMode(chr4kMode), .chr8kBank(chr8kBank));

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    checkVal(req, "ctrlReg", ctrlReg, mRegs[0]);
    checkVal(req, "chrLoReg", chrLoReg, mRegs[1]);
    checkVal(req, "chrHiReg", chrHiReg, mRegs[2]);
    checkVal(req, "prgReg", prgReg, mRegs[3]);
    checkVal("R7", "mirror", mirror, mRegs[0][1:0] ^ 2'b11);
    checkVal("R8", "prg16Mode", prg16Mode, mRegs[0][3]);
    checkVal("R8", "prgLowSwitch", prgLowSwitch, mRegs[0][2]);
    checkVal("R9", "chr4kMode", chr4kMode, mRegs[0][4]);
    checkVal("R9", "chr8kBank", chr8kBank, mRegs[1][4:1]);
  endtask

  function automatic void modelReset();
    mRegs[0] = 5'h0C; mRegs[1] = '0; mRegs[2] = '0; mRegs[3] = '0;
    mShift = '0; mCnt = 0; mFilt = 0;
  endfunction

  function automatic void modelStep(input logic w, input logic [15:0] a, input logic [7:0] d);
    if (w && a[15]) begin
      if (d[7]) begin
        mShift = '0; mCnt = 0; mRegs[0] = mRegs[0] | 5'h0C;
      end else if (mFilt == 0) begin
        mShift[mCnt] = d[0];
        mCnt++;
        if (mCnt == 5) begin
          mRegs[a[14:13]] = mShift;
          mShift = '0; mCnt = 0;
        end
      end
      mFilt = 2;
    end else if (mFilt > 0) mFilt--;
  endfunction

  task automatic tick(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStb = w; wrAddr = a; wrData = d;
    @(posedge clk);
    modelStep(w, a, d);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0, 8'h0);
  endtask

  task automatic wrSpaced(input logic [15:0] a, input logic [7:0] d);
    tick(1'b1, a, d);
    idle(2);
  endtask

  task automatic loadValue(input logic [1:0] sel, input logic [4:0] val);
    for (int i = 0; i < 5; i++) wrSpaced({1'b1, sel, 13'h0}, {7'h0, val[i]});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    modelReset();
    repeat (3) @(negedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R6: power-up state
    checkAll("R6");

    // R3 / R2: one register of each number, LSB-first assembly
    loadValue(2'd3, 5'h13); checkAll("R3");
    checkVal("R2", "prgReg order", prgReg, 5'h13);
    loadValue(2'd1, 5'h0B); checkAll("R3");
    checkVal("R9", "chr8kBank", chr8kBank, 4'h5);
    loadValue(2'd2, 5'h1E); checkAll("R3");
    loadValue(2'd0, 5'h11); checkAll("R3");
    checkVal("R7", "mirror", mirror, 2'b10);
    checkVal("R8", "prg16Mode", prg16Mode, 1'b0);
    checkVal("R9", "chr4kMode", chr4kMode, 1'b1);

    // R1: partial word abandoned, control bits 3:2 forced, others kept
    wrSpaced(16'hE000, 8'h01);
    wrSpaced(16'hE000, 8'h01);
    tick(1'b1, 16'h8000, 8'h80); checkAll("R1");
    checkVal("R1", "ctrlReg force", ctrlReg, 5'h1D);
    idle(2);
    loadValue(2'd3, 5'h04); checkAll("R1");
    checkVal("R1", "prgReg after abandon", prgReg, 5'h04);
    // R1: reset write during active filter still applies
    loadValue(2'd0, 5'h00);
    tick(1'b1, 16'hC000, 8'h00);
    tick(1'b1, 16'h8000, 8'hFF); checkAll("R1");
    checkVal("R1", "ctrlReg under filter", ctrlReg, 5'h0C);
    idle(2);

    // R4: writes 1 and 2 cycles apart are dropped, 3 apart accepted
    tick(1'b1, 16'hE000, 8'h01);
    tick(1'b1, 16'hE000, 8'h01);
    idle(1);
    tick(1'b1, 16'hE000, 8'h01);
    idle(2);
    for (int i = 0; i < 4; i++) wrSpaced(16'hE000, 8'h00);
    checkAll("R4");
    checkVal("R4", "prgReg filtered", prgReg, 5'h01);

    // R5: out-of-range and strobe-less traffic has no effect
    tick(1'b1, 16'h6000, 8'h80);
    tick(1'b0, 16'hE000, 8'h81);
    tick(1'b1, 16'h7FFF, 8'h01);
    checkAll("R5");
    checkVal("R5", "ctrlReg untouched", ctrlReg, mRegs[0]);
    loadValue(2'd2, 5'h15);
    checkVal("R5", "chrHiReg clean load", chrHiReg, 5'h15);

    // Random mix: back-to-back writes, low addresses, rare reset writes
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [15:0] a;
      logic [7:0] d;
      w = ($urandom % 3) != 0;
      a = 16'($urandom);
      if (($urandom % 5) != 0) a[15] = 1'b1;
      d = 8'($urandom);
      if (($urandom % 12) != 0) d[7] = 1'b0;
      tick(w, a, d);
      if (n % 8 == 0) checkAll("R3");
    end
    checkAll("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule